// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block is a two-wire serial bus target that looks like a 256-byte EEPROM with a single one-byte location pointer. It is meant to sit on a bench or inside a larger design as the device an I2C controller talks to. Bus lines are sampled with the local clock through a synchronizer. START and STOP are recognised from SDA moving while SCL is high. The target answers only to its own 7-bit device address. It never drives SDA high: it only asserts a pull-low enable, and an open-drain pad outside the block turns that into the wire level.

A write transaction carries the device address, then one pointer byte, then any number of data bytes. The data bytes go into the internal array at successive locations. A read transaction returns bytes from the pointer onward. The pointer survives STOP and START, so a read goes on from wherever the last access stopped, in both directions. A write-protect input blocks storage but leaves the bus handshake and the pointer movement unchanged. The block has no stream interface at its edge: the two bus lines and the protect pin are plain levels, and the open-drain wire is the only flow control, set by the controller's clock.

Top module: `i2cee_slave`

## Requirements
- R1: While reset is held and right after it, `sda_pull_o` is low, and the target waits for a START.
- R2: The target acknowledges (pulls SDA low during the ninth clock) only a device byte whose upper seven bits equal `DEV_ADDR` (default 7'b1010000). The lowest bit selects the direction: 0 for write, 1 for read. After any other device byte it does not pull SDA until the next START or STOP, and it acknowledges no later byte.
- R3: In a write, the first byte after the device byte loads the location pointer and is acknowledged. A transaction with only that byte leaves the pointer at the loaded value.
- R4: In a write, each later byte is acknowledged and stored at the pointer, and the pointer then advances by one. It wraps from 255 to 0. After the transaction the pointer is one past the last stored byte.
- R5: The pointer keeps its value across STOP and START. A read starts at the pointer and advances it after every byte sent, both within one transaction and across several.
- R6: While `wp_i` is high, write data bytes are still acknowledged and still advance the pointer, but the array is left unchanged.
- R7: In a read, the target releases SDA for the ninth clock of each byte. If the controller acknowledges (SDA low), the next byte follows. If it does not (SDA high), the target drives nothing until the next START.
- R8: A START at any point, including in the middle of a byte, restarts reception with a fresh device byte. A STOP returns the target to idle with SDA released.
- R9: `sda_pull_o` changes only while SCL is low, except in the cycle after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| wp_i | input | 1 | Write protect: high blocks storage of data bytes |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
Each SCL edge goes through two synchronizer flops and one history flop before the controller sees it. The state register then takes one more clock, so `sda_pull_o` answers a falling SCL about three local clocks later. The bench holds each SCL half period for ten local clocks. It changes SDA only five clocks after SCL falls, which is after the target's answer has settled. It samples the wire on a falling clock edge at the end of each high phase. During every received bit it also samples the wire a second time, early in the high phase, and compares the two samples to check that the target leaves SDA alone while SCL is high.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } ee_state_e;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_PTR,
    BY_DATA
  } byte_kind_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2cee_bus_sync.sv
module i2cee_bus_sync
  import i2cee_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;
  logic              sda_s;

  // Shift chain: new sample enters at bit 0, settled value leaves at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_comb begin
    evt.scl   = scl_s;
    evt.sda   = sda_s;
    evt.rise  = scl_s & ~scl_d;
    evt.fall  = ~scl_s & scl_d;
    evt.start = scl_s & scl_d & sda_d & ~sda_s;
    evt.stop  = scl_s & scl_d & ~sda_d & sda_s;
  end

endmodule

// File: rtl/i2cee_store.sv
module i2cee_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] rdata,
  output logic              mem_we,
  output logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              ptr_ld,
  output logic              sda_pull
);

  localparam int          CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  ee_state_e         st;
  byte_kind_e        kind;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rd_mode;
  logic              m_ack;
  logic              byte_done;

  assign byte_done = (st == ST_RX) && evt.fall && (bitcnt == FULL_CNT);
  assign mem_we    = byte_done && (kind == BY_DATA) && !wp_i;
  assign ptr_ld    = byte_done && (kind == BY_PTR);
  assign wdata     = rx_sh;
  assign sda_pull  = (st == ST_RX_ACK) || ((st == ST_TX) && !tx_sh[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= BY_DEV;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      m_ack   <= 1'b0;
    end else if (evt.stop) begin
      st <= ST_IDLE;
    end else if (evt.start) begin
      st     <= ST_RX;
      kind   <= BY_DEV;
      bitcnt <= '0;
    end else begin
      case (st)
        ST_RX: begin
          if (evt.rise && bitcnt != FULL_CNT) begin
            rx_sh  <= {rx_sh[BYTE_W-2:0], evt.sda};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_done) begin
            case (kind)
              BY_DEV: begin
                if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                  rd_mode <= rx_sh[0];
                  st      <= ST_RX_ACK;
                end else begin
                  st <= ST_SKIP;
                end
              end
              BY_PTR: begin
                ptr <= rx_sh;
                st  <= ST_RX_ACK;
              end
              default: begin
                ptr <= ptr + 1'b1;
                st  <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (evt.fall) begin
            bitcnt <= '0;
            if (kind == BY_DEV && rd_mode) begin
              tx_sh <= rdata;
              ptr   <= ptr + 1'b1;
              st    <= ST_TX;
            end else begin
              st   <= ST_RX;
              kind <= (kind == BY_DEV) ? BY_PTR : BY_DATA;
            end
          end
        end
        ST_TX: begin
          if (evt.fall) begin
            if (bitcnt == LAST_TX) begin
              st <= ST_TX_ACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (evt.rise) m_ack <= ~evt.sda;
          if (evt.fall) begin
            if (m_ack) begin
              tx_sh  <= rdata;
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              st     <= ST_TX;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o
);

  bus_evt_t          evt_w;
  logic              we_w;
  logic [BYTE_W-1:0] wdata_w;
  logic [BYTE_W-1:0] rdata_w;
  logic [PTR_W-1:0]  ptr_w;
  logic              ptr_ld_w;

  i2cee_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt_w)
  );

  i2cee_ctrl #(.DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_w),
    .wp_i     (wp_i),
    .rdata    (rdata_w),
    .mem_we   (we_w),
    .wdata    (wdata_w),
    .ptr      (ptr_w),
    .ptr_ld   (ptr_ld_w),
    .sda_pull (sda_pull_o)
  );

  i2cee_store #(.AW(PTR_W), .DW(BYTE_W)) i_store (
    .clk   (clk),
    .we    (we_w),
    .waddr (ptr_w),
    .wdata (wdata_w),
    .raddr (ptr_w),
    .rdata (rdata_w)
  );

endmodule

// File: rtl/i2cee_slave_chk.sv
module i2cee_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start,
  input logic       stop,
  input logic       wp_i,
  input logic       we,
  input logic [7:0] ptr,
  input logic       ptr_ld,
  input logic       sda_pull_o
);

  AST_PULL_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start) && !$past(stop)) |-> $stable(sda_pull_o)); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_pull_o); // R8

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sda_pull_o); // R8

  AST_WP_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !wp_i); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == 8'($past(ptr) + 8'd1)) || $past(ptr_ld))); // R5

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!sda_pull_o); // R1
  end

endmodule

bind i2cee_slave i2cee_slave_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (evt_w.scl),
  .start      (evt_w.start),
  .stop       (evt_w.stop),
  .wp_i       (wp_i),
  .we         (we_w),
  .ptr        (ptr_w),
  .ptr_ld     (ptr_ld_w),
  .sda_pull_o (sda_pull_o)
);

// File: tb/test_i2cee_slave.sv
module test_i2cee_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int SETTLE     = 5;
  localparam int NVEC       = 6;
  // {location, value}
  localparam logic [15:0] VEC [NVEC] = '{16'h003C, 16'h47A5, 16'h8001,
                                         16'hC3FF, 16'h2A00, 16'h996E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic pull;
  logic sda_bus;
  int   checks = 0;
  int   errors = 0;
  logic done = 1'b0;

  assign sda_bus = sda_m & ~pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cee_slave i_i2cee_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .wp_i       (wp),
    .sda_pull_o (pull)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl = 1'b1;   wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl = 1'b0;   wt(SETTLE);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl = 1'b1;   wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(HALF);
    scl = 1'b1; wt(HALF);
    scl = 1'b0; wt(SETTLE);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wt(HALF);
    scl = 1'b1;   wt(HALF);
    ack = ~sda_bus;
    scl = 1'b0;   wt(SETTLE);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic early;
    logic moved = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(HALF);
      scl = 1'b1;   wt(3);
      early = sda_bus;
      wt(HALF - 3);
      b[i] = sda_bus;
      if (early !== b[i]) moved = 1'b1;
      scl = 1'b0;   wt(SETTLE);
    end
    chk("R9 data stable while SCL high", {7'd0, moved}, 8'd0);
    put_bit(~give_ack);
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic k;
    bus_start(); send_byte(8'hA0, k); send_byte(a, k); bus_stop();
  endtask

  task automatic read_one(output logic [7:0] b);
    logic k;
    bus_start(); send_byte(8'hA1, k); recv_byte(1'b0, b); bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       k;
    logic [7:0] d;
    wt(5);
    chk("R1 pull low in reset", {7'd0, pull}, 8'd0);
    rst_n = 1'b1;
    wt(20);
    chk("R1 pull low after reset", {7'd0, pull}, 8'd0);

    // Table: store one byte, repoint, read it back.
    for (int v = 0; v < NVEC; v++) begin
      bus_start(); send_byte(8'hA0, k); send_byte(VEC[v][15:8], k);
      send_byte(VEC[v][7:0], k); bus_stop();
      chk("R4 table write ack", {7'd0, k}, 8'd1);
      set_ptr(VEC[v][15:8]);
      read_one(d);
      chk("R5 table readback", d, VEC[v][7:0]);
    end

    // R2: foreign address gets no ack, nor do later bytes.
    bus_start(); send_byte(8'hA4, k);
    chk("R2 foreign address nack", {7'd0, k}, 8'd0);
    send_byte(8'h00, k);
    chk("R2 ignored until STOP", {7'd0, k}, 8'd0);
    bus_stop();
    chk("R8 released after STOP", {7'd0, pull}, 8'd0);

    // R3 and R4: sequential write across the wrap point.
    bus_start(); send_byte(8'hA0, k);
    chk("R2 own address ack", {7'd0, k}, 8'd1);
    send_byte(8'hFE, k);
    chk("R3 pointer byte ack", {7'd0, k}, 8'd1);
    send_byte(8'hD1, k); send_byte(8'hD2, k); send_byte(8'hD3, k);
    bus_stop();
    set_ptr(8'hFE);
    bus_start(); send_byte(8'hA1, k);
    recv_byte(1'b1, d); chk("R7 read byte 0", d, 8'hD1);
    recv_byte(1'b1, d); chk("R7 read byte 1", d, 8'hFF - 8'h2D);
    recv_byte(1'b0, d); chk("R4 wrap to location 0", d, 8'hD3);
    bus_stop();

    // R5: pointer persists across transactions.
    bus_start(); send_byte(8'hA0, k); send_byte(8'h10, k);
    send_byte(8'h44, k); send_byte(8'h55, k); send_byte(8'h66, k); bus_stop();
    set_ptr(8'h10);
    read_one(d); chk("R3 pointer-only write then read", d, 8'h44);
    read_one(d); chk("R5 next transaction continues", d, 8'h55);

    // R4: after a write the pointer sits one past the last stored byte.
    bus_start(); send_byte(8'hA0, k); send_byte(8'h21, k); send_byte(8'h88, k); bus_stop();
    bus_start(); send_byte(8'hA0, k); send_byte(8'h20, k); send_byte(8'h70, k); bus_stop();
    read_one(d); chk("R4 pointer one past last write", d, 8'h88);

    // R6: write protect.
    wp = 1'b1;
    bus_start(); send_byte(8'hA0, k); send_byte(8'h10, k); send_byte(8'h99, k); bus_stop();
    chk("R6 protected data still acked", {7'd0, k}, 8'd1);
    wp = 1'b0;
    read_one(d); chk("R6 pointer advanced under protect", d, 8'h55);
    set_ptr(8'h10);
    read_one(d); chk("R6 protected location unchanged", d, 8'h44);

    // R7: after NACK nothing is driven until START.
    set_ptr(8'h10);
    bus_start(); send_byte(8'hA1, k);
    recv_byte(1'b0, d); chk("R7 byte before NACK", d, 8'h44);
    recv_byte(1'b0, d); chk("R7 silent after NACK", d, 8'hFF);
    bus_stop();

    // R8: START in the middle of a byte.
    bus_start();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_start(); send_byte(8'hA0, k);
    chk("R8 restart mid-byte then address ack", {7'd0, k}, 8'd1);
    send_byte(8'h20, k); bus_stop();
    read_one(d); chk("R8 pointer load after restart", d, 8'h70);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule